// File: doc/BRIEF.md
# I2C Master Command Sequencer

This block is the register-facing front end of an I2C master. Software loads bytes into a transmit queue and issues START, RESTART and STOP commands by writing a command register. After a START, the first byte taken from the queue is the target address and direction. In extended mode, two bytes form a 10-bit address. Each bus action goes to a byte-level bus engine over a valid/ready request with a one-cycle completion pulse: address phase, byte write, byte read and stop. The bit-level SCL/SDA timing lives in that engine, outside this block.

Write data stays queued until a RESTART or STOP releases it to the target. Read transfers fetch a programmed number of bytes into a receive queue. Software drains that queue through the same data register. An address that no target acknowledges aborts the transfer and raises a timeout flag. Status bits report activity, queue state and three sticky event flags, which are cleared by writing ones.

The register bus has one port. A write takes effect at the clock edge where it is sampled. The data for a read appears on `bus_rdata` from the next edge onward. Offsets: control 0x00, status 0x04, receive flush 0x1C, receive count 0x20, transmit flush 0x24, data 0x2C, command 0x30. The engine operation codes are 0 address, 1 write byte, 2 read byte and 3 stop.

Top module: `i2c_cmd_seq`

## Requirements
- R1: After reset the block is disabled and idle. Status (0x04) reads 0x00A: bit 1 means receive queue empty and bit 3 means transmit queue empty. The command register reads 0, and no engine request is made.
- R2: Writing command bit 0 starts a transfer only when the block is enabled and idle. A start written while busy has no effect. Command bit 0 reads 1 while not idle. Status bits 0 and 5 are both 1 while not idle.
- R3: With command bit 7 clear, the first queued byte after a start issues an address operation. The target address is bits 7:1 of that byte. Bit 0 gives the direction, where 1 means read.
- R4: With command bit 7 set, the first byte supplies the direction in bit 0 and address bits 9:8 in bits 2:1. The second byte supplies address bits 7:0. The address operation is then flagged as 10-bit.
- R5: After an acknowledged read address, the block issues as many read operations as the count in 0x20 bits 7:0, where a count of 0 means 256. Returned bytes enter the receive queue in order. No read is issued while the queue is full.
- R6: If the address is not acknowledged, the block sets the timeout flag (status bit 10), empties the transmit queue and returns to idle. It issues no further operation.
- R7: In write direction, queued bytes are held until a command. STOP (command bit 2) sends them in order, then issues a stop operation, sets the stop (bit 9) and done (bit 8) flags and returns to idle. RESTART (command bit 1) sends them, sets done and returns to the address phase without a stop operation. Bits 1 and 2 read back 0.
- R8: Data-register writes made while a read is being fetched or drained are discarded. The transmit level (0x24 bits 15:8) stays 0.
- R9: Reading the data register while the receive queue is empty returns 0 and sets the done flag.
- R10: Any write to control (0x00) forces idle without a stop operation. Bit 0 is the enable. While disabled, data-register writes and commands have no effect.
- R11: Writing ones to status bits 8 to 10 clears the matching flags. Writing bit 7 of 0x1C or 0x24 empties the receive or transmit queue.
- R12: The receive level appears in bits 15:8 of 0x20, and the programmed count reads back in bits 7:0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | AW | Register byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, registered |
| eng_valid | output | 1 | Engine operation request |
| eng_ready | input | 1 | Engine accepts a request |
| eng_op | output | 2 | Operation: 0 address, 1 write, 2 read, 3 stop |
| eng_addr | output | 10 | Target address for address operation |
| eng_ten | output | 1 | Address is 10-bit |
| eng_rd | output | 1 | Direction of address operation, 1 read |
| eng_wbyte | output | 8 | Byte to write |
| eng_done | input | 1 | Completion pulse of the accepted operation |
| eng_nack | input | 1 | Address not acknowledged, valid with eng_done |
| eng_rbyte | input | 8 | Byte read, valid with eng_done |

## Verification
Register reads return data one edge after the strobe, so the bench drives a strobe at a falling edge and samples `bus_rdata` at the next falling edge. Engine completions arrive three cycles after acceptance in the bench model, and each completion takes effect on the edge after the pulse. For that reason the checks on state that follows a command never sample at a fixed cycle. They poll the busy status bit, or wait a margin of at least ten cycles, before reading results. The order of engine operations is checked from a log that the engine model keeps, never from the block's internals.

// File: rtl/i2c_cmd_seq.sv
module i2c_cmd_seq #(
  parameter int DEPTH = 8,
  parameter int AW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_wr,
  input  logic          bus_rd,
  input  logic [AW-1:0] bus_addr,
  input  logic [31:0]   bus_wdata,
  output logic [31:0]   bus_rdata,
  output logic          eng_valid,
  input  logic          eng_ready,
  output logic [1:0]    eng_op,
  output logic [9:0]    eng_addr,
  output logic          eng_ten,
  output logic          eng_rd,
  output logic [7:0]    eng_wbyte,
  input  logic          eng_done,
  input  logic          eng_nack,
  input  logic [7:0]    eng_rbyte
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [AW-1:0] A_CTL = AW'(8'h00), A_STAT = AW'(8'h04), A_RXF = AW'(8'h1C),
                            A_RXC = AW'(8'h20), A_TXF = AW'(8'h24), A_DATA = AW'(8'h2C),
                            A_CMD = AW'(8'h30);
  localparam logic [1:0] OP_ADDR = 2'd0, OP_WR = 2'd1, OP_RD = 2'd2, OP_STOP = 2'd3;
  localparam logic [1:0] P_NONE = 2'd0, P_RST = 2'd1, P_STOP = 2'd2;

  typedef enum logic [2:0] {S_IDLE, S_READY, S_WADDR, S_READ, S_RBUF, S_WRITE} st_t;

  st_t         st;
  logic        en, sea, wait_q, dir_q;
  logic [1:0]  op_q, pend, hi_q;
  logic [7:0]  rxcnt;
  logic [8:0]  remain;
  logic        f_done, f_stop, f_to;

  logic [7:0]  tx_mem [DEPTH];
  logic [7:0]  rx_mem [DEPTH];
  logic [PW-1:0] tx_rp, tx_wp, rx_rp, rx_wp;
  logic [CW-1:0] tx_n, rx_n;

  logic unused_hi;
  assign unused_hi = ^bus_wdata[31:11];

  wire tx_empty = (tx_n == '0);
  wire tx_full  = (tx_n == CW'(DEPTH));
  wire rx_empty = (rx_n == '0);
  wire rx_full  = (rx_n == CW'(DEPTH));
  wire busy     = (st != S_IDLE);
  wire [7:0] tx_head = tx_mem[tx_rp];

  wire ctl_wr   = bus_wr && bus_addr == A_CTL;
  wire stat_wr  = bus_wr && bus_addr == A_STAT;
  wire rxcnt_wr = bus_wr && bus_addr == A_RXC;
  wire cmd_wr   = bus_wr && bus_addr == A_CMD;
  wire data_wr  = bus_wr && bus_addr == A_DATA && en;
  wire data_rd  = bus_rd && bus_addr == A_DATA && en;
  wire draining = (st == S_READ) || (st == S_RBUF);

  wire do_start = cmd_wr && en && bus_wdata[0] && !busy;
  wire do_stop  = cmd_wr && en && bus_wdata[2];
  wire do_rst   = cmd_wr && en && bus_wdata[1] && !bus_wdata[2];

  wire res      = wait_q && eng_done;
  wire addr_res = res && op_q == OP_ADDR && (st == S_READY || st == S_WADDR);
  wire nack_abort = addr_res && eng_nack;
  wire sea_take = !wait_q && st == S_READY && pend == P_NONE && sea && !tx_empty;

  logic       iss;
  logic [1:0] i_op;
  logic [9:0] i_addr;
  logic       i_ten, i_rd;

  always_comb begin
    iss = 1'b0; i_op = OP_ADDR; i_addr = '0; i_ten = 1'b0; i_rd = 1'b0;
    if (!wait_q) begin
      case (st)
        S_READY: if (pend == P_STOP) begin iss = 1'b1; i_op = OP_STOP; end
                 else if (pend == P_NONE && !sea && !tx_empty) begin
                   iss = 1'b1; i_addr = {3'b000, tx_head[7:1]}; i_rd = tx_head[0];
                 end
        S_WADDR: if (pend == P_STOP) begin iss = 1'b1; i_op = OP_STOP; end
                 else if (pend == P_NONE && !tx_empty) begin
                   iss = 1'b1; i_addr = {hi_q, tx_head}; i_ten = 1'b1; i_rd = dir_q;
                 end
        S_READ:  if (pend == P_STOP) begin iss = 1'b1; i_op = OP_STOP; end
                 else if (pend == P_NONE && remain != '0 && !rx_full) begin
                   iss = 1'b1; i_op = OP_RD;
                 end
        S_RBUF:  if (pend == P_STOP) begin iss = 1'b1; i_op = OP_STOP; end
        S_WRITE: if (pend != P_NONE && !tx_empty) begin iss = 1'b1; i_op = OP_WR; end
                 else if (pend == P_STOP) begin iss = 1'b1; i_op = OP_STOP; end
        default: ;
      endcase
    end
  end

  assign eng_valid = iss;
  assign eng_op    = i_op;
  assign eng_addr  = i_addr;
  assign eng_ten   = i_ten;
  assign eng_rd    = i_rd;
  assign eng_wbyte = tx_head;

  wire fire    = iss && eng_ready;
  wire tx_pop  = (fire && (i_op == OP_ADDR || i_op == OP_WR)) || sea_take;
  wire tx_push = data_wr && !draining && !tx_full;
  wire tx_clr  = nack_abort || (bus_wr && bus_addr == A_TXF && bus_wdata[7]);
  wire rx_push = res && op_q == OP_RD && st == S_READ && !rx_full;
  wire rx_pop  = data_rd && !rx_empty;
  wire rx_clr  = bus_wr && bus_addr == A_RXF && bus_wdata[7];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_rp <= '0; tx_wp <= '0; tx_n <= '0;
    end else if (tx_clr) begin
      tx_rp <= '0; tx_wp <= '0; tx_n <= '0;
    end else begin
      if (tx_push) begin tx_mem[tx_wp] <= bus_wdata[7:0]; tx_wp <= PW'((tx_wp + 1'b1) % DEPTH); end
      if (tx_pop) tx_rp <= PW'((tx_rp + 1'b1) % DEPTH);
      tx_n <= tx_n + CW'(tx_push) - CW'(tx_pop);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_rp <= '0; rx_wp <= '0; rx_n <= '0;
    end else if (rx_clr) begin
      rx_rp <= '0; rx_wp <= '0; rx_n <= '0;
    end else begin
      if (rx_push) begin rx_mem[rx_wp] <= eng_rbyte; rx_wp <= PW'((rx_wp + 1'b1) % DEPTH); end
      if (rx_pop) rx_rp <= PW'((rx_rp + 1'b1) % DEPTH);
      rx_n <= rx_n + CW'(rx_push) - CW'(rx_pop);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; en <= 1'b0; sea <= 1'b0; wait_q <= 1'b0; dir_q <= 1'b0;
      op_q <= OP_ADDR; pend <= P_NONE; hi_q <= '0; rxcnt <= '0; remain <= '0;
      f_done <= 1'b0; f_stop <= 1'b0; f_to <= 1'b0;
    end else begin
      if (stat_wr) begin
        if (bus_wdata[8]) f_done <= 1'b0;
        if (bus_wdata[9]) f_stop <= 1'b0;
        if (bus_wdata[10]) f_to <= 1'b0;
      end
      if (rxcnt_wr) rxcnt <= bus_wdata[7:0];
      if (data_rd && rx_empty) f_done <= 1'b1;

      if (eng_done) wait_q <= 1'b0;
      if (fire) begin
        wait_q <= 1'b1;
        op_q <= i_op;
        if (i_op == OP_ADDR) dir_q <= i_rd;
      end
      if (sea_take) begin
        st <= S_WADDR; hi_q <= tx_head[2:1]; dir_q <= tx_head[0];
      end

      if (addr_res) begin
        if (eng_nack) begin
          f_to <= 1'b1; st <= S_IDLE; pend <= P_NONE;
        end else begin
          st <= dir_q ? S_READ : S_WRITE;
          remain <= (rxcnt == 8'd0) ? 9'd256 : {1'b0, rxcnt};
        end
      end
      if (rx_push) begin
        remain <= remain - 9'd1;
        if (remain == 9'd1) st <= S_RBUF;
      end
      if (res && op_q == OP_STOP && busy) begin
        st <= S_IDLE; pend <= P_NONE; f_stop <= 1'b1; f_done <= 1'b1;
      end

      if (!wait_q && pend == P_RST && busy && !(st == S_WRITE && !tx_empty)) begin
        st <= S_READY; pend <= P_NONE;
        if (st == S_WRITE) f_done <= 1'b1;
      end

      if (cmd_wr) sea <= bus_wdata[7];
      if (do_start) begin st <= S_READY; pend <= P_NONE; end
      if (busy) begin
        if (do_stop) pend <= P_STOP;
        else if (do_rst && pend != P_STOP) pend <= P_RST;
      end else if (do_stop) begin
        f_stop <= 1'b1; f_done <= 1'b1;
      end

      if (ctl_wr) begin
        en <= bus_wdata[0]; st <= S_IDLE; pend <= P_NONE;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) bus_rdata <= '0;
    else if (bus_rd) begin
      case (bus_addr)
        A_CTL:  bus_rdata <= {31'd0, en};
        A_STAT: bus_rdata <= {21'd0, f_to, f_stop, f_done, 2'b00, busy, tx_full, tx_empty,
                              rx_full, rx_empty, busy};
        A_RXC:  bus_rdata <= (32'(rx_n) << 8) | {24'd0, rxcnt};
        A_RXF:  bus_rdata <= 32'(rx_n) << 8;
        A_TXF:  bus_rdata <= 32'(tx_n) << 8;
        A_DATA: bus_rdata <= (en && !rx_empty) ? {24'd0, rx_mem[rx_rp]} : 32'd0;
        A_CMD:  bus_rdata <= {24'd0, sea, 6'd0, busy};
        default: bus_rdata <= '0;
      endcase
    end
  end
endmodule

// File: rtl/i2c_cmd_seq_chk.sv
module i2c_cmd_seq_chk #(
  parameter int DEPTH = 8,
  parameter int AW = 8,
  parameter int CW = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          en,
  input logic [2:0]    st,
  input logic          wait_q,
  input logic [1:0]    op_q,
  input logic          eng_valid,
  input logic          eng_done,
  input logic          eng_nack,
  input logic          f_done,
  input logic          f_stop,
  input logic          f_to,
  input logic [CW-1:0] tx_n,
  input logic [CW-1:0] rx_n,
  input logic          bus_rd,
  input logic [AW-1:0] bus_addr,
  input logic [31:0]   bus_rdata
);
  a_r10_quiet_when_off: assert property (@(posedge clk) disable iff (!rst_n)
    !en |-> !eng_valid);

  a_r6_nack_aborts: assert property (@(posedge clk) disable iff (!rst_n)
    (wait_q && eng_done && eng_nack && op_q == 2'd0 && (st == 3'd1 || st == 3'd2))
    |=> (st == 3'd0 && tx_n == '0 && f_to));

  a_r7_stop_flags: assert property (@(posedge clk) disable iff (!rst_n)
    (wait_q && eng_done && op_q == 2'd3 && st != 3'd0) |=> (st == 3'd0 && f_stop && f_done));

  a_r5_rx_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    rx_n <= CW'(DEPTH));

  a_r9_empty_read: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && bus_addr == AW'(8'h2C) && en && rx_n == '0) |=> (bus_rdata == 32'd0 && f_done));
endmodule

bind i2c_cmd_seq i2c_cmd_seq_chk #(.DEPTH(DEPTH), .AW(AW), .CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .en(en), .st(st), .wait_q(wait_q), .op_q(op_q),
  .eng_valid(eng_valid), .eng_done(eng_done), .eng_nack(eng_nack),
  .f_done(f_done), .f_stop(f_stop), .f_to(f_to), .tx_n(tx_n), .rx_n(rx_n),
  .bus_rd(bus_rd), .bus_addr(bus_addr), .bus_rdata(bus_rdata));

// File: tb/tb_i2c_cmd_seq.sv
module tb_i2c_cmd_seq;
  localparam int CLK_PERIOD = 10;
  localparam logic [9:0] TGT7 = 10'h03A, TGT10 = 10'h2C5;

  logic clk = 0, rst_n = 0;
  logic bus_wr = 0, bus_rd = 0;
  logic [7:0] bus_addr = 0;
  logic [31:0] bus_wdata = 0, bus_rdata;
  logic eng_valid, eng_ready, eng_ten, eng_rd, eng_done, eng_nack;
  logic [1:0] eng_op;
  logic [9:0] eng_addr;
  logic [7:0] eng_wbyte, eng_rbyte;

  int n_tests = 0, n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  i2c_cmd_seq dut (.*);

  logic busy_m = 0, cnt_m = 0, nack_m = 0;
  logic [1:0] opm;
  logic [7:0] rseq = 0;
  logic [1:0] log_op [1024];
  logic [11:0] log_val [1024];
  int n_log = 0;
  assign eng_ready = !busy_m;

  always @(posedge clk) begin
    eng_done <= 1'b0;
    if (busy_m) begin
      if (cnt_m) cnt_m <= 1'b0;
      else begin
        eng_done <= 1'b1; eng_nack <= nack_m; busy_m <= 1'b0;
        if (opm == 2'd2) begin eng_rbyte <= rseq; rseq <= rseq + 8'd1; end
      end
    end else if (eng_valid && rst_n) begin
      busy_m <= 1'b1; cnt_m <= 1'b1; opm <= eng_op;
      nack_m <= (eng_op == 2'd0) &&
                !((!eng_ten && eng_addr == TGT7) || (eng_ten && eng_addr == TGT10));
      log_op[n_log] <= eng_op;
      log_val[n_log] <= (eng_op == 2'd0) ? {eng_ten, eng_rd, eng_addr} :
                        (eng_op == 2'd1) ? {4'd0, eng_wbyte} :
                        (eng_op == 2'd2) ? {4'd0, rseq} : 12'd0;
      n_log <= n_log + 1;
    end
  end

  initial begin eng_done = 0; eng_nack = 0; eng_rbyte = 0; end

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    @(negedge clk); bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_wr = 0;
  endtask

  task automatic rd(logic [7:0] a, output logic [31:0] d);
    @(negedge clk); bus_rd = 1; bus_addr = a;
    @(negedge clk); bus_rd = 0; d = bus_rdata;
  endtask

  task automatic idle_wait();
    logic [31:0] s;
    for (int i = 0; i < 2000; i++) begin
      rd(8'h04, s);
      if (!s[0]) return;
    end
  endtask

  task automatic pause(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset_disabled();
    logic [31:0] v;
    rd(8'h04, v); check("R1 status", v, 32'h00A);
    rd(8'h30, v); check("R1 cmd", v, 0);
    wr(8'h2C, 32'h74); wr(8'h30, 32'h1); pause(10);
    rd(8'h04, v); check("R10 disabled start", v, 32'h00A);
    rd(8'h24, v); check("R10 disabled fifo write", v, 0);
    check("R1 no engine ops", n_log, 0);
  endtask

  task automatic t_write_stop();
    logic [31:0] v; int b = n_log;
    wr(8'h30, 32'h1); wr(8'h2C, 32'h74); wr(8'h2C, 32'h11); pause(10);
    rd(8'h30, v); check("R2 cmd busy readback", v, 32'h01);
    rd(8'h04, v); check("R2 busy bits", v & 32'h21, 32'h21);
    wr(8'h30, 32'h1); wr(8'h2C, 32'h22); wr(8'h2C, 32'h33); pause(10);
    check("R7 writes held", n_log - b, 1);
    wr(8'h30, 32'h4); rd(8'h30, v); check("R7 stop reads 0", v & 32'h6, 0);
    idle_wait();
    check("R7 op count", n_log - b, 5);
    check("R3 addr op", {log_op[b], log_val[b]}, {2'd0, 12'h03A});
    check("R7 w1", {log_op[b+1], log_val[b+1]}, {2'd1, 12'h011});
    check("R2 start ignored", {log_op[b+2], log_val[b+2]}, {2'd1, 12'h022});
    check("R7 w3", {log_op[b+3], log_val[b+3]}, {2'd1, 12'h033});
    check("R7 stop op", log_op[b+4], 2'd3);
    rd(8'h04, v); check("R7 flags", v, 32'h30A);
    wr(8'h04, 32'h700); rd(8'h04, v); check("R11 w1c", v, 32'h00A);
  endtask

  task automatic t_restart_read();
    logic [31:0] v; int b = n_log;
    wr(8'h20, 32'h3);
    wr(8'h30, 32'h1); wr(8'h2C, 32'h74); wr(8'h2C, 32'h55); pause(6);
    wr(8'h30, 32'h2); pause(12);
    rd(8'h04, v); check("R7 restart done", v[8], 1);
    wr(8'h2C, 32'h75); pause(30);
    wr(8'h2C, 32'h99);
    rd(8'h24, v); check("R8 discarded", v, 0);
    rd(8'h20, v); check("R12 level and count", v, 32'h303);
    for (int i = 0; i < 3; i++) begin
      rd(8'h2C, v); check("R5 data", v, i);
    end
    wr(8'h30, 32'h4); idle_wait();
    check("R7 op count restart", n_log - b, 7);
    check("R7 restart no stop", {log_op[b+1], log_op[b+2]}, {2'd1, 2'd0});
    check("R3 read dir", log_val[b+2], {2'b01, 10'h03A});
    check("R5 read ops", {log_op[b+3], log_op[b+5], log_op[b+6]}, {2'd2, 2'd2, 2'd3});
    wr(8'h04, 32'h700);
  endtask

  task automatic t_empty_read();
    logic [31:0] v;
    rd(8'h2C, v); check("R9 zero", v, 0);
    rd(8'h04, v); check("R9 done", v, 32'h10A);
    wr(8'h04, 32'h100);
  endtask

  task automatic t_nack();
    logic [31:0] v; int b = n_log;
    wr(8'h2C, 32'h20); wr(8'h2C, 32'hAA); wr(8'h2C, 32'hBB);
    rd(8'h24, v); check("R11 tx level", v, 32'h300);
    wr(8'h30, 32'h1); idle_wait(); pause(10);
    rd(8'h04, v); check("R6 timeout flushed", v, 32'h40A);
    check("R6 only addr", n_log - b, 1);
    check("R6 addr", log_val[b], 12'h010);
    wr(8'h2C, 32'h5); wr(8'h24, 32'h80);
    rd(8'h24, v); check("R11 tx flush", v, 0);
    wr(8'h04, 32'h700);
  endtask

  task automatic t_ten();
    logic [31:0] v; int b = n_log;
    wr(8'h20, 32'h2);
    wr(8'h30, 32'h81); wr(8'h2C, 32'hF5); wr(8'h2C, 32'hC5); pause(30);
    rd(8'h30, v); check("R4 sea readback", v, 32'h81);
    check("R4 ten addr", {log_op[b], log_val[b]}, {2'd0, 2'b11, TGT10});
    rd(8'h2C, v); check("R4 d0", v, 3);
    rd(8'h2C, v); check("R4 d1", v, 4);
    wr(8'h30, 32'h84); idle_wait();
    check("R4 ops", n_log - b, 4);
    wr(8'h30, 32'h0); wr(8'h04, 32'h700);
  endtask

  task automatic t_256();
    logic [31:0] v; int b = n_log; int nr = 0; logic [7:0] e = 8'd5;
    wr(8'h20, 32'h0); rd(8'h20, v); check("R12 count zero", v & 32'hFF, 0);
    wr(8'h30, 32'h1); wr(8'h2C, 32'h75);
    for (int i = 0; i < 256; i++) begin
      for (int k = 0; k < 100; k++) begin
        rd(8'h04, v);
        if (!v[1]) break;
      end
      rd(8'h2C, v);
      if (v[7:0] !== e) check("R5 stream", v, {24'd0, e});
      e = e + 8'd1;
    end
    check("R5 stream end", {24'd0, e}, 32'd5);
    pause(10);
    rd(8'h04, v); check("R5 busy after 256", v & 32'h3, 32'h3);
    wr(8'h30, 32'h4); idle_wait();
    for (int i = b; i < n_log; i++) if (log_op[i] == 2'd2) nr++;
    check("R5 256 reads", nr, 256);
    wr(8'h04, 32'h700);
  endtask

  task automatic t_abort();
    logic [31:0] v; int b = n_log;
    wr(8'h30, 32'h1); wr(8'h2C, 32'h74); pause(10);
    wr(8'h00, 32'h1); rd(8'h04, v); check("R10 forced idle", v[0], 0);
    pause(20); check("R10 no stop", n_log - b, 1);
    wr(8'h00, 32'h0); wr(8'h2C, 32'h74); wr(8'h30, 32'h1);
    rd(8'h24, v); check("R10 off fifo", v, 0);
    rd(8'h04, v); check("R10 off cmd", v[0], 0);
    wr(8'h00, 32'h1);
  endtask

  initial begin
    for (int i = 0; i < 200000; i++) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL watchdog actual=%0d expected=0", 1);
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    pause(3); rst_n = 1; pause(2);
    t_reset_disabled();
    wr(8'h00, 32'h1);
    t_write_stop();
    t_restart_read();
    t_empty_read();
    t_nack();
    t_ten();
    t_256();
    t_abort();
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule